// File: doc/BRIEF.md
# Power Zone Phase Shedding Controller

This block decides how many phases of a multiphase buck regulator are switching and whether they run in discontinuous conduction. It turns a three-level mode input, a digitized total-current code, four current thresholds and two fixed-zone settings into a power zone number. It then turns that zone into a per-phase enable mask, taking the number of phases fitted on the board into account.

The mode input has three meanings. In high mode, every fitted phase is used. In mid mode, the current code is sampled at a fixed interval and compared against the thresholds, so that phases are shed as the load falls. In low mode, a zone chosen by software is used.

Between enable and the moment the output reaches its nominal voltage, the mode seen at enable is frozen and automatic shedding is held off. If the mode was low at enable, the normal low-mode zone is used only after the mode has left low and later returned to it.

Configuration registers are loaded through a plain write strobe. There is no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `pzone_ctrl`

## Requirements
- R1: While `en` is low, including after reset, the zone is 0, `phase_en` has one bit set for each fitted phase, and `dcm` is 0. The zone returns to 0 one cycle after `en` falls.
- R2: When `run` holds, `run` meaning `en` is high and `nominal` has been seen since enable, and `mode[1]` is 1 (high mode), the zone becomes 0 one cycle later.
- R3: In mid mode while running, a sample compares `cur_code` against the thresholds. The comparison is strictly greater-than, and a code equal to a threshold counts as not above it. The sampled zone is:
  - 0 if the code is above threshold 4;
  - otherwise 1 if it is above threshold 3;
  - otherwise 2 if it is above threshold 2;
  - otherwise 3 if it is above threshold 1;
  - otherwise 4.
- R4: A threshold register holding 0xFF is disabled, and the code is never above it. With all four thresholds disabled, mid mode selects zone 4.
- R5: In mid mode, the zone changes only at a sample. The sample counter is cleared whenever the block is not running in mid mode. The first sample takes effect `SAMPLE_CYC` clock edges after mid mode starts, and later samples follow every `SAMPLE_CYC` edges.
- R6: In low mode, the boot zone setting (address 5) applies from enable until `nominal` is seen. After that, the normal setting (address 4) applies once the block is armed.
- R7: If the mode is low when `en` rises, the block is unarmed. The boot setting stays in force until the mode, while running, leaves low for mid or high and then returns to low. Only then does the normal setting take effect.
- R8: Between enable and `nominal`, changes on `mode` are ignored. If the mode at enable was mid or high, the zone stays 0, so mid mode does no shedding in this window. Once `nominal` is seen, the live mode takes effect.
- R9: Zone legalisation by fitted phase count `phase_cnt` (1..8):
  - zone 1 needs 8 phases;
  - zone 2 needs 8, 6 or 4 phases;
  - zone 3 with 1 phase is reported as zone 0.
  
  A zone that is not allowed falls back to zone 0.
- R10: `phase_en` bit i drives phase i+1. The mask for each zone is:
  - zone 0 enables phases 1..`phase_cnt`;
  - zone 1 enables phases 1, 3, 5 and 7;
  - zone 2 enables phase 1 and phase `phase_cnt`/2+1, which gives 0x11, 0x09 or 0x05;
  - zones 3 and 4 enable phase 1 only.
- R11: `dcm` is 1 exactly when the reported zone is 4. Zones 0 to 3 are continuous mode.
- R12: The write port takes 8-bit data.
  - Addresses 0 to 3 hold thresholds 1 to 4, and reset to 0xFF.
  - Address 4 is the normal low-mode zone and address 5 is the boot zone. Both reset to 0, and setting values 5 to 7 act as zone 4.
  - A write takes effect at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Regulator enable |
| nominal | input | 1 | Output voltage has reached its nominal value |
| mode | input | 2 | 00 low, 01 mid, 1x high |
| cur_code | input | CW | Digitized total load current |
| phase_cnt | input | PCW | Number of fitted phases, 1..NPH |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| zone | output | 3 | Reported power zone, 0..4 |
| phase_en | output | NPH | Per-phase enable mask |
| dcm | output | 1 | Discontinuous-mode request |

## Verification
The assertions take for granted that:
- `phase_cnt` lies in 1..8 and changes only while the block is idle or between samples;
- `nominal` is treated as a level that may rise at any time after enable.

The bench drives every input at the falling clock edge. It keeps `phase_cnt` within that range, and it lets the sample counter restart by leaving mid mode before changing thresholds in bulk. Because it tracks the sample phase itself, each check of a held zone lands one cycle before a sample and each check of a new zone lands just after one.

// File: rtl/pz_pkg.sv
package pz_pkg;
  localparam int ZW       = 3;
  localparam int ZONE_TOP = 4;

  localparam logic [1:0] MODE_LOW = 2'b00;
  localparam logic [1:0] MODE_MID = 2'b01;

  function automatic logic [ZW-1:0] clamp_zone(input logic [ZW-1:0] z);
    return (z > ZW'(ZONE_TOP)) ? ZW'(ZONE_TOP) : z;
  endfunction
endpackage

// File: rtl/pz_regs.sv
module pz_regs #(
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [CW-1:0]       wr_data,
  output logic [3:0][CW-1:0]  thr,
  output logic [2:0]          lo_norm,
  output logic [2:0]          lo_boot
);
  for (genvar i = 0; i < 4; i++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                thr[i] <= '1;
      else if (wr_en && wr_addr == 3'(i))        thr[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_norm <= '0;
      lo_boot <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd4) lo_norm <= wr_data[2:0];
      if (wr_addr == 3'd5) lo_boot <= wr_data[2:0];
    end
  end
endmodule

// File: rtl/pz_sampler.sv
module pz_sampler #(
  parameter int CW         = 8,
  parameter int SAMPLE_CYC = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [CW-1:0]      cur_code,
  input  logic [3:0][CW-1:0] thr,
  output logic               tick,
  output logic [2:0]         cmp_zone
);
  localparam int CNTW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;

  logic [CNTW-1:0] cnt;
  logic [3:0]      above;

  assign tick = active && (cnt == CNTW'(SAMPLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!active || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_cmp
    assign above[i] = (thr[i] != '1) && (cur_code > thr[i]);
  end

  always_comb begin
    if      (above[3]) cmp_zone = 3'd0;
    else if (above[2]) cmp_zone = 3'd1;
    else if (above[1]) cmp_zone = 3'd2;
    else if (above[0]) cmp_zone = 3'd3;
    else               cmp_zone = 3'd4;
  end

  // R5: interval counter never passes the sample limit
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(SAMPLE_CYC - 1));
  // R5: counter restarts whenever sampling is inactive
  a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0);
endmodule

// File: rtl/pz_select.sv
module pz_select
  import pz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       nominal,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic [2:0] cmp_zone,
  input  logic [2:0] lo_norm,
  input  logic [2:0] lo_boot,
  output logic       run_mid,
  output logic [2:0] zone_req
);
  logic       nom_q, armed_q, run;
  logic [1:0] cap_q, eff;
  logic [2:0] zone_q, zone_d;

  assign run      = en && (nom_q || nominal);
  assign eff      = run ? mode : cap_q;
  assign run_mid  = run && (mode == MODE_MID);
  assign zone_req = zone_q;

  always_comb begin
    zone_d = 3'd0;
    if (en) begin
      if (eff == MODE_LOW)
        zone_d = clamp_zone((run && armed_q) ? lo_norm : lo_boot);
      else if (eff == MODE_MID && run)
        zone_d = tick ? cmp_zone : zone_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_q   <= 1'b0;
      armed_q <= 1'b0;
      cap_q   <= MODE_LOW;
      zone_q  <= 3'd0;
    end else begin
      zone_q <= zone_d;
      if (!en) begin
        nom_q   <= 1'b0;
        cap_q   <= mode;
        armed_q <= (mode != MODE_LOW);
      end else begin
        nom_q   <= nom_q || nominal;
        armed_q <= armed_q || (run && mode != MODE_LOW);
      end
    end
  end

  // R1: disabled drops the zone to 0
  a_r1_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> zone_q == 3'd0);
  // R2: running in high mode selects zone 0
  a_r2_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode[1]) |=> zone_q == 3'd0);
  // R5: no zone change in mid mode away from a sample
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mid && !tick) |=> $stable(zone_q));
  // R7: unarmed low mode keeps the boot setting
  a_r7_unarmed_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_LOW && !armed_q) |=> zone_q == clamp_zone($past(lo_boot)));
endmodule

// File: rtl/pz_map.sv
module pz_map #(
  parameter int NPH = 8,
  parameter int PCW = 4
) (
  input  logic [2:0]     zone_req,
  input  logic [PCW-1:0] phase_cnt,
  output logic [2:0]     zone,
  output logic [NPH-1:0] phase_en,
  output logic           dcm
);
  logic [PCW-1:0] pcc;
  logic [NPH-1:0] act, alt_pat, pair_pat;
  logic [2:0]     zc;
  logic           z1_ok, z2_ok;

  assign pcc = (phase_cnt == '0) ? PCW'(1) :
               (phase_cnt > PCW'(NPH)) ? PCW'(NPH) : phase_cnt;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign act[i]      = PCW'(i) < pcc;
    assign alt_pat[i]  = (i % 2) == 0;
    assign pair_pat[i] = (i == 0) || (PCW'(i) == (pcc >> 1));
  end

  assign z1_ok = (pcc == PCW'(8));
  assign z2_ok = (pcc == PCW'(8)) || (pcc == PCW'(6)) || (pcc == PCW'(4));

  always_comb begin
    zc   = pz_pkg::clamp_zone(zone_req);
    zone = zc;
    if ((zc == 3'd1 && !z1_ok) || (zc == 3'd2 && !z2_ok) ||
        (zc == 3'd3 && pcc == PCW'(1)))
      zone = 3'd0;
    case (zone)
      3'd0:    phase_en = act;
      3'd1:    phase_en = act & alt_pat;
      3'd2:    phase_en = act & pair_pat;
      default: phase_en = NPH'(1);
    endcase
    dcm = (zone == 3'd4);
  end
endmodule

// File: rtl/pzone_ctrl.sv
module pzone_ctrl #(
  parameter int NPH        = 8,
  parameter int CW         = 8,
  parameter int SAMPLE_CYC = 1000,
  localparam int PCW       = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           nominal,
  input  logic [1:0]     mode,
  input  logic [CW-1:0]  cur_code,
  input  logic [PCW-1:0] phase_cnt,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [2:0]     zone,
  output logic [NPH-1:0] phase_en,
  output logic           dcm
);
  logic [3:0][CW-1:0] thr;
  logic [2:0]         lo_norm, lo_boot, cmp_zone, zone_req;
  logic               tick, run_mid;

  pz_regs #(.CW(CW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .thr, .lo_norm, .lo_boot
  );

  pz_sampler #(.CW(CW), .SAMPLE_CYC(SAMPLE_CYC)) u_samp (
    .clk, .rst_n, .active(run_mid), .cur_code, .thr,
    .tick, .cmp_zone
  );

  pz_select u_sel (
    .clk, .rst_n, .en, .nominal, .mode, .tick, .cmp_zone,
    .lo_norm, .lo_boot, .run_mid, .zone_req
  );

  pz_map #(.NPH(NPH), .PCW(PCW)) u_map (
    .zone_req, .phase_cnt, .zone, .phase_en, .dcm
  );

  // R9: zone 1 is reported only with eight fitted phases
  a_r9_zone1_needs8: assert property (@(posedge clk) disable iff (!rst_n)
    zone == 3'd1 |-> phase_cnt == PCW'(8));
  // R10: no phase beyond the fitted count is ever enabled
  a_r10_mask_in_fit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt >= PCW'(1) && phase_cnt <= PCW'(NPH)) |->
      (phase_en >> phase_cnt) == '0);
  // R10: phase 1 always switches
  a_r10_phase1_on: assert property (@(posedge clk) disable iff (!rst_n)
    phase_en[0]);
  // R11: discontinuous mode only in zone 4, never while disabled
  a_r11_dcm_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dcm);
endmodule

// File: tb/pzone_ctrl_tb.sv
module pzone_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 6;

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, nominal = 1'b0, wr_en = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [7:0] cur_code = '0, wr_data = '0;
  logic [3:0] phase_cnt = 4'd8;
  logic [2:0] wr_addr = '0;
  logic [2:0] zone;
  logic [7:0] phase_en;
  logic       dcm;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] thr_m [4];
  int prev_req;

  pzone_ctrl #(.NPH(8), .CW(8), .SAMPLE_CYC(S)) u_dut (
    .clk, .rst_n, .en, .nominal, .mode, .cur_code, .phase_cnt,
    .wr_en, .wr_addr, .wr_data, .zone, .phase_en, .dcm
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int legal(int req, int pc);
    int z = (req > 4) ? 4 : req;
    if (z == 1 && pc != 8) z = 0;
    if (z == 2 && !(pc == 8 || pc == 6 || pc == 4)) z = 0;
    if (z == 3 && pc == 1) z = 0;
    return z;
  endfunction

  function automatic int mask_of(int z, int pc);
    case (z)
      0: return (1 << pc) - 1;
      1: return 8'h55;
      2: return 1 | (1 << (pc / 2));
      default: return 1;
    endcase
  endfunction

  function automatic int cmp_of(logic [7:0] c);
    if (thr_m[3] != 8'hFF && c > thr_m[3]) return 0;
    if (thr_m[2] != 8'hFF && c > thr_m[2]) return 1;
    if (thr_m[1] != 8'hFF && c > thr_m[1]) return 2;
    if (thr_m[0] != 8'hFF && c > thr_m[0]) return 3;
    return 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag, int req);
    int pc = int'(phase_cnt);
    int z  = legal(req, pc);
    chk({tag, " zone"}, int'(zone), z);
    chk({tag, " R10 mask"}, int'(phase_en), mask_of(z, pc));
    chk({tag, " R11 dcm"}, int'(dcm), (z == 4) ? 1 : 0);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (a < 4) thr_m[a] = 8'(d);
  endtask

  task automatic mid_step(logic [7:0] code);
    int nreq;
    cur_code = code;
    cyc(S - 1);
    check_out("R5 hold", prev_req);
    cyc(1);
    nreq = cmp_of(code);
    check_out("R3 sample", nreq);
    prev_req = nreq;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [11] = '{8'h00, 8'h20, 8'h21, 8'h40, 8'h41, 8'h60,
                               8'h61, 8'h80, 8'h81, 8'hFF, 8'h30};
    int pcs [4] = '{8, 6, 4, 1};
    for (int i = 0; i < 4; i++) thr_m[i] = 8'hFF;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check_out("R1 reset", 0);

    wr(0, 8'h20); wr(1, 8'h40); wr(2, 8'h60); wr(3, 8'h80);

    // R2: high mode, every phase count
    en = 1'b1; nominal = 1'b1; mode = 2'b10;
    cyc(2);
    for (int pc = 1; pc <= 8; pc++) begin
      phase_cnt = 4'(pc); #1;
      check_out("R2 high", 0);
    end
    phase_cnt = 4'd8;

    // R6/R7: low at power-up
    en = 1'b0; nominal = 1'b0; mode = 2'b00;
    wr(5, 3); wr(4, 2);
    cyc(1);
    en = 1'b1; cyc(2);
    check_out("R6 boot zone", 3);
    nominal = 1'b1; cyc(2);
    check_out("R7 unarmed", 3);
    mode = 2'b10; cyc(2);
    check_out("R2 leave low", 0);
    mode = 2'b00; cyc(2);
    check_out("R7 reentered low", 2);

    // R8: mode ignored until nominal
    en = 1'b0; nominal = 1'b0; mode = 2'b01; cur_code = 8'h00;
    cyc(2);
    check_out("R1 disabled", 0);
    en = 1'b1; cyc(S + 2);
    check_out("R8 no shedding", 0);
    mode = 2'b00; cyc(2);
    check_out("R8 ignored", 0);
    nominal = 1'b1; cyc(2);
    check_out("R8 live mode", 2);

    // R6/R12/R9: normal low setting sweep
    for (int s = 0; s < 8; s++) begin
      wr(4, s); cyc(1);
      for (int pc = 1; pc <= 8; pc++) begin
        phase_cnt = 4'(pc); #1;
        check_out("R6 R12 R9 low", s);
      end
    end
    phase_cnt = 4'd8; #1;
    prev_req = 4;

    // R3/R5: mid mode sampling
    mode = 2'b01;
    foreach (pcs[p]) begin
      phase_cnt = 4'(pcs[p]);
      foreach (codes[k]) mid_step(codes[k]);
    end
    phase_cnt = 4'd8;

    // R4: threshold 4 disabled mid-window
    cur_code = 8'hFF;
    wr(3, 8'hFF);
    cyc(S - 2);
    check_out("R4 hold", prev_req);
    cyc(1);
    check_out("R4 th4 off", 1);
    chk("R4 expect zone1", cmp_of(8'hFF), 1);

    // R4: all thresholds disabled
    mode = 2'b10; cyc(1);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
    cyc(1);
    check_out("R2 high again", 0);
    prev_req = 0;
    mode = 2'b01;
    mid_step(8'hFF);
    chk("R4 all off", int'(zone), 4);

    en = 1'b0; cyc(2);
    check_out("R1 disable end", 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule